// File: doc/BRIEF.md
# Reset Classification and Restart Sequencer

This block is the reset state machine of a power-management controller. It watches a set of fault and request strobes and sorts each one into one of two classes. A system-class event powers the device down and does not bring it back up. A device-class event powers it down and then brings it back up on its own. The block drives the active-low reset output. It hands "shut down" and "start up" requests to the converter sequencer and waits for that sequencer to report each step done. It caps repeated automatic restarts, and it records which cause produced the latest return to the running state.

The states are NO_POWER (code 0), OFF (1), BACKUP (2), STARTUP (3), STRETCH (4), ON (5) and SHUTDOWN (6). The transitions are:
- NO_POWER to OFF on the first clock after power-on reset is released.
- OFF or BACKUP to STARTUP on a valid ON event.
- STARTUP to STRETCH when the sequencer reports startup done.
- STRETCH to ON when the stretch time runs out.
- STARTUP, STRETCH or ON to SHUTDOWN when a cause is accepted.
- SHUTDOWN to STARTUP, BACKUP or OFF when the sequencer reports shutdown done. Which of the three is taken depends on the class of the accepted cause and on the retry caps.

The analog detectors, the converter sequencing and the register storage live outside the block. The block only issues a one-cycle register-clear pulse. That pulse clears the ordinary register map; the real-time clock and the scratch registers keep their contents.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `pwr_state` is 0 (NO_POWER), `rst_n` is 0 and `on_src` is 0. On the first clock edge after `por_n` goes high, `pwr_state` becomes 1 (OFF).
- R2: In OFF (1) or BACKUP (2), `on_evt` moves the block to STARTUP (3), where `startup_req` is 1. The same event clears both retry counters.
- R3: The following are system causes: `seq_tmo`, `over_temp`, `sys_sd_lvl`, `sw_off`, and `sys_lo` while `sys_lo_off_en` is 1. An accepted system cause moves the block to SHUTDOWN (6), where `shutdown_req` is 1. When `shutdown_done` arrives, the block goes to OFF (1) and does not restart.
- R4: `core_uv` is also a system cause. When it is among the active system causes, the block goes to BACKUP (2) after shutdown instead of OFF.
- R5: Three inputs have no effect while their enable is 0: `sys_lo` without `sys_lo_off_en`, `wdog_exp` without `wdog_dev_en`, and `conv_uv` without `conv_dev_en`. In that case the block stays in ON with `rst_n` high.
- R6: The device causes are `ext_pin_low`, `wdog_exp` with `wdog_dev_en`, `conv_uv` with `conv_dev_en`, and `sw_rst`. When one is accepted, the block shuts down and then goes to STARTUP. `regmap_clr` is 1 for exactly the first cycle of that STARTUP.
- R7: When several causes arrive in the same cycle, any system cause wins over every device cause. Among device causes, the order is the external pin, then the watchdog, then the converter, then the software reset.
- R8: `rst_n` goes low in the cycle after a cause is accepted. It stays low through SHUTDOWN, OFF, BACKUP, STARTUP and STRETCH, and it is high only in ON.
- R9: STRETCH lasts STRETCH_UNIT × 2^`rst_dur` clock cycles. Counting starts from the edge that samples `startup_done`.
- R10: `on_src` changes only on entry to ON. It then holds the cause of that return: 1 for an ON event, 2 for the external pin, 3 for the watchdog, 4 for the converter, 5 for a software reset.
- R11: Watchdog and converter restarts share one counter with a cap of 6. Once 6 restarts have been granted, the next watchdog or converter cause ends in OFF (1).
- R12: Software resets have their own counter with a cap of 6. This counter does not depend on the shared watchdog/converter counter.
- R13: After `stable_limit` consecutive cycles in ON, both retry counters are cleared.
- R14: Causes are accepted only in STARTUP, STRETCH and ON. In OFF, a cause leaves the state at OFF and `rst_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| on_evt | input | 1 | Valid ON event |
| seq_tmo | input | 1 | Power sequence startup timeout |
| over_temp | input | 1 | Overtemperature |
| sys_lo | input | 1 | Supply below user low threshold |
| sys_lo_off_en | input | 1 | User low threshold acts as an OFF cause |
| sys_sd_lvl | input | 1 | Supply below shutdown level |
| sw_off | input | 1 | Software OFF command |
| core_uv | input | 1 | Core supply undervoltage |
| wdog_exp | input | 1 | Watchdog expired |
| wdog_dev_en | input | 1 | Watchdog expiry causes a device restart |
| ext_pin_low | input | 1 | Reset pin pulled low externally |
| conv_uv | input | 1 | Converter undervoltage |
| conv_dev_en | input | 1 | Converter undervoltage causes a device restart |
| sw_rst | input | 1 | Software reset write |
| shutdown_done | input | 1 | Shutdown sequence complete |
| startup_done | input | 1 | Startup sequence complete |
| rst_dur | input | 2 | Stretch select: STRETCH_UNIT × 1, 2, 4 or 8 |
| stable_limit | input | STABLE_W | Cycles in ON before the retry counters clear |
| rst_n | output | 1 | Active-low reset output |
| shutdown_req | output | 1 | Shutdown sequence request |
| startup_req | output | 1 | Startup sequence request |
| regmap_clr | output | 1 | One-cycle register map clear pulse |
| pwr_state | output | 3 | Current state code |
| on_src | output | 3 | Cause of the last return to ON |

## Verification
The classifier is driven with every cause on its own. This separates OFF from BACKUP from restart and checks each source code. It is then driven with mixed patterns, such as a system cause together with a device cause, and several device causes at once, which expose the priority order. Cause inputs asserted without their enable show that a gated input neither shuts down nor steals priority from a lower cause. Long runs of watchdog, converter and software restarts, with and without a stable ON period between them, tell the shared counter, the separate software counter and the two clearing paths apart.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_NOPWR   = 3'd0,
        ST_OFF     = 3'd1,
        ST_BACKUP  = 3'd2,
        ST_START   = 3'd3,
        ST_STRETCH = 3'd4,
        ST_ON      = 3'd5,
        ST_SHDN    = 3'd6
    } pstate_e;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_WC   = 2'd1,
        GRP_SW   = 2'd2
    } grp_e;

    localparam logic [2:0] SRC_NONE  = 3'd0;
    localparam logic [2:0] SRC_ONEV  = 3'd1;
    localparam logic [2:0] SRC_PIN   = 3'd2;
    localparam logic [2:0] SRC_WDOG  = 3'd3;
    localparam logic [2:0] SRC_CONV  = 3'd4;
    localparam logic [2:0] SRC_SWRST = 3'd5;

    typedef struct packed {
        logic       valid;
        logic       is_dev;
        logic       to_backup;
        logic [2:0] src;
        grp_e       grp;
    } cause_t;

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
    import rsq_pkg::*;
(
    input  logic   seq_tmo,
    input  logic   over_temp,
    input  logic   sys_lo,
    input  logic   sys_lo_off_en,
    input  logic   sys_sd_lvl,
    input  logic   sw_off,
    input  logic   core_uv,
    input  logic   wdog_exp,
    input  logic   wdog_dev_en,
    input  logic   ext_pin_low,
    input  logic   conv_uv,
    input  logic   conv_dev_en,
    input  logic   sw_rst,
    output cause_t cause
);

    logic sys_any;

    assign sys_any = seq_tmo | over_temp | (sys_lo & sys_lo_off_en)
                   | sys_sd_lvl | sw_off | core_uv;

    // System class first, then device causes in fixed priority order
    always_comb begin
        cause = '0;
        if (sys_any) begin
            cause.valid     = 1'b1;
            cause.is_dev    = 1'b0;
            cause.to_backup = core_uv;
            cause.src       = SRC_NONE;
            cause.grp       = GRP_NONE;
        end else if (ext_pin_low) begin
            cause.valid  = 1'b1;
            cause.is_dev = 1'b1;
            cause.src    = SRC_PIN;
            cause.grp    = GRP_NONE;
        end else if (wdog_exp && wdog_dev_en) begin
            cause.valid  = 1'b1;
            cause.is_dev = 1'b1;
            cause.src    = SRC_WDOG;
            cause.grp    = GRP_WC;
        end else if (conv_uv && conv_dev_en) begin
            cause.valid  = 1'b1;
            cause.is_dev = 1'b1;
            cause.src    = SRC_CONV;
            cause.grp    = GRP_WC;
        end else if (sw_rst) begin
            cause.valid  = 1'b1;
            cause.is_dev = 1'b1;
            cause.src    = SRC_SWRST;
            cause.grp    = GRP_SW;
        end
    end

endmodule

// File: rtl/rsq_retry.sv
module rsq_retry #(
    parameter int NGRP      = 2,
    parameter int MAX_RETRY = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NGRP-1:0] inc,
    output logic [NGRP-1:0] full
);

    localparam int CW = $clog2(MAX_RETRY + 1);

    for (genvar g = 0; g < NGRP; g++) begin : g_cnt
        logic [CW-1:0] cnt;

        assign full[g] = (cnt >= CW'(MAX_RETRY));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (clr) begin
                cnt <= {{(CW-1){1'b0}}, inc[g]};
            end else if (inc[g] && !full[g]) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsq_tick.sv
module rsq_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    assign hit = en && (cnt == (limit - W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int STRETCH_UNIT = 1000,
    parameter int MAX_RETRY    = 6,
    parameter int STABLE_W     = 16
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                on_evt,
    input  logic                seq_tmo,
    input  logic                over_temp,
    input  logic                sys_lo,
    input  logic                sys_lo_off_en,
    input  logic                sys_sd_lvl,
    input  logic                sw_off,
    input  logic                core_uv,
    input  logic                wdog_exp,
    input  logic                wdog_dev_en,
    input  logic                ext_pin_low,
    input  logic                conv_uv,
    input  logic                conv_dev_en,
    input  logic                sw_rst,
    input  logic                shutdown_done,
    input  logic                startup_done,
    input  logic [1:0]          rst_dur,
    input  logic [STABLE_W-1:0] stable_limit,
    output logic                rst_n,
    output logic                shutdown_req,
    output logic                startup_req,
    output logic                regmap_clr,
    output logic [2:0]          pwr_state,
    output logic [2:0]          on_src
);

    localparam int STRETCH_MAX = STRETCH_UNIT * 8;
    localparam int SW_W        = $clog2(STRETCH_MAX + 1);
    localparam int NGRP        = 2;
    localparam int IDX_WC      = 0;
    localparam int IDX_SW      = 1;

    pstate_e st, nxt;

    cause_t           cause;
    logic             in_window;
    logic             accept;
    logic             capped;
    logic             restart_ok;
    logic [NGRP-1:0]  grp_inc;
    logic [NGRP-1:0]  grp_full;
    logic             cnt_clr;
    logic             power_up;
    logic             stretch_hit;
    logic             stable_hit;
    logic [SW_W-1:0]  stretch_lim;

    logic             sd_restart;
    logic             sd_backup;
    logic [2:0]       pend_src;
    logic [2:0]       on_src_q;
    logic             regmap_clr_q;

    rsq_classify u_cls (
        .seq_tmo       (seq_tmo),
        .over_temp     (over_temp),
        .sys_lo        (sys_lo),
        .sys_lo_off_en (sys_lo_off_en),
        .sys_sd_lvl    (sys_sd_lvl),
        .sw_off        (sw_off),
        .core_uv       (core_uv),
        .wdog_exp      (wdog_exp),
        .wdog_dev_en   (wdog_dev_en),
        .ext_pin_low   (ext_pin_low),
        .conv_uv       (conv_uv),
        .conv_dev_en   (conv_dev_en),
        .sw_rst        (sw_rst),
        .cause         (cause)
    );

    assign in_window  = (st == ST_START) || (st == ST_STRETCH) || (st == ST_ON);
    assign accept     = in_window && cause.valid;
    assign capped     = ((cause.grp == GRP_WC) && grp_full[IDX_WC])
                     || ((cause.grp == GRP_SW) && grp_full[IDX_SW]);
    assign restart_ok = cause.is_dev && !capped;
    assign power_up   = ((st == ST_OFF) || (st == ST_BACKUP)) && on_evt;
    assign cnt_clr    = power_up || stable_hit;

    assign grp_inc[IDX_WC] = accept && restart_ok && (cause.grp == GRP_WC);
    assign grp_inc[IDX_SW] = accept && restart_ok && (cause.grp == GRP_SW);

    rsq_retry #(
        .NGRP      (NGRP),
        .MAX_RETRY (MAX_RETRY)
    ) u_retry (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (cnt_clr),
        .inc   (grp_inc),
        .full  (grp_full)
    );

    assign stretch_lim = SW_W'(STRETCH_UNIT) << rst_dur;

    rsq_tick #(.W(SW_W)) u_stretch (
        .clk   (clk),
        .rst_n (por_n),
        .en    (st == ST_STRETCH),
        .limit (stretch_lim),
        .hit   (stretch_hit)
    );

    rsq_tick #(.W(STABLE_W)) u_stable (
        .clk   (clk),
        .rst_n (por_n),
        .en    (st == ST_ON),
        .limit (stable_limit),
        .hit   (stable_hit)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st <= ST_NOPWR;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_NOPWR:   nxt = ST_OFF;
            ST_OFF,
            ST_BACKUP:  if (on_evt) nxt = ST_START;
            ST_START: begin
                if (accept)            nxt = ST_SHDN;
                else if (startup_done) nxt = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (accept)           nxt = ST_SHDN;
                else if (stretch_hit) nxt = ST_ON;
            end
            ST_ON:      if (accept) nxt = ST_SHDN;
            ST_SHDN: begin
                if (shutdown_done) begin
                    if (sd_restart)     nxt = ST_START;
                    else if (sd_backup) nxt = ST_BACKUP;
                    else                nxt = ST_OFF;
                end
            end
            default:    nxt = ST_OFF;
        endcase
    end

    // Cause bookkeeping that travels through the shutdown/startup handshakes
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sd_restart   <= 1'b0;
            sd_backup    <= 1'b0;
            pend_src     <= SRC_NONE;
            on_src_q     <= SRC_NONE;
            regmap_clr_q <= 1'b0;
        end else begin
            regmap_clr_q <= (st == ST_SHDN) && shutdown_done && sd_restart;
            if (accept) begin
                sd_restart <= restart_ok;
                sd_backup  <= cause.to_backup;
                pend_src   <= cause.src;
            end
            if (power_up) begin
                pend_src <= SRC_ONEV;
            end
            if ((st == ST_STRETCH) && stretch_hit && !accept) begin
                on_src_q <= pend_src;
            end
        end
    end

    // Outputs
    always_comb begin
        rst_n        = (st == ST_ON);
        shutdown_req = (st == ST_SHDN);
        startup_req  = (st == ST_START);
        regmap_clr   = regmap_clr_q;
        pwr_state    = st;
        on_src       = on_src_q;
    end

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
    input logic       clk,
    input logic       por_n,
    input logic       on_evt,
    input logic       shutdown_done,
    input logic       rst_n,
    input logic       shutdown_req,
    input logic       regmap_clr,
    input logic [2:0] pwr_state,
    input logic [2:0] on_src
);

    p_rst_low_in_shutdown_r8: assert property (@(posedge clk) disable iff (!por_n)
        shutdown_req |-> !rst_n);

    p_release_after_stretch_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> ($past(pwr_state) == 3'd4));

    p_clear_single_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
        regmap_clr |=> !regmap_clr);

    p_clear_on_restart_r6: assert property (@(posedge clk) disable iff (!por_n)
        regmap_clr |-> (pwr_state == 3'd3) && ($past(pwr_state) == 3'd6));

    p_off_holds_r14: assert property (@(posedge clk) disable iff (!por_n)
        ((pwr_state == 3'd1) && !on_evt) |=> (pwr_state == 3'd1));

    p_src_only_on_entry_r10: assert property (@(posedge clk) disable iff (!por_n)
        (on_src != $past(on_src)) |-> (pwr_state == 3'd5) && ($past(pwr_state) == 3'd4));

    p_shutdown_exit_r3: assert property (@(posedge clk) disable iff (!por_n)
        ((pwr_state == 3'd6) && shutdown_done) |=>
            ((pwr_state == 3'd1) || (pwr_state == 3'd2) || (pwr_state == 3'd3)));

endmodule

bind rst_seq_ctrl rsq_checker u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .on_evt        (on_evt),
    .shutdown_done (shutdown_done),
    .rst_n         (rst_n),
    .shutdown_req  (shutdown_req),
    .regmap_clr    (regmap_clr),
    .pwr_state     (pwr_state),
    .on_src        (on_src)
);

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;

    localparam int UNIT = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic on_evt = 0, seq_tmo = 0, over_temp = 0, sys_lo = 0, sys_lo_off_en = 0;
    logic sys_sd_lvl = 0, sw_off = 0, core_uv = 0, wdog_exp = 0, wdog_dev_en = 0;
    logic ext_pin_low = 0, conv_uv = 0, conv_dev_en = 0, sw_rst = 0;
    logic shutdown_done = 0, startup_done = 0;
    logic [1:0]  rst_dur = 2'd0;
    logic [15:0] stable_limit = 16'd4;
    logic rst_n, shutdown_req, startup_req, regmap_clr;
    logic [2:0] pwr_state, on_src;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rst_seq_ctrl #(.STRETCH_UNIT(UNIT)) uut (
        .clk(clk), .por_n(por_n), .on_evt(on_evt), .seq_tmo(seq_tmo),
        .over_temp(over_temp), .sys_lo(sys_lo), .sys_lo_off_en(sys_lo_off_en),
        .sys_sd_lvl(sys_sd_lvl), .sw_off(sw_off), .core_uv(core_uv),
        .wdog_exp(wdog_exp), .wdog_dev_en(wdog_dev_en), .ext_pin_low(ext_pin_low),
        .conv_uv(conv_uv), .conv_dev_en(conv_dev_en), .sw_rst(sw_rst),
        .shutdown_done(shutdown_done), .startup_done(startup_done),
        .rst_dur(rst_dur), .stable_limit(stable_limit), .rst_n(rst_n),
        .shutdown_req(shutdown_req), .startup_req(startup_req),
        .regmap_clr(regmap_clr), .pwr_state(pwr_state), .on_src(on_src)
    );

    // fault word: [12]seq [11]otemp [10]syslo [9]syslo_en [8]sdlvl [7]swoff
    // [6]coreuv [5]wdog [4]wdog_en [3]pin [2]conv [1]conv_en [0]swrst
    // entry: {fault, expected state after shutdown (5 = no shutdown), expected on_src}
    localparam logic [18:0] TBL [19] = '{
        {13'h1000, 3'd1, 3'd0}, {13'h0800, 3'd1, 3'd0}, {13'h0600, 3'd1, 3'd0},
        {13'h0100, 3'd1, 3'd0}, {13'h0080, 3'd1, 3'd0}, {13'h0040, 3'd2, 3'd0},
        {13'h0008, 3'd3, 3'd2}, {13'h0030, 3'd3, 3'd3}, {13'h0006, 3'd3, 3'd4},
        {13'h0001, 3'd3, 3'd5}, {13'h003F, 3'd3, 3'd2}, {13'h0037, 3'd3, 3'd3},
        {13'h0007, 3'd3, 3'd4}, {13'h0808, 3'd1, 3'd0}, {13'h0140, 3'd2, 3'd0},
        {13'h0400, 3'd5, 3'd0}, {13'h0020, 3'd5, 3'd0}, {13'h0004, 3'd5, 3'd0},
        {13'h0021, 3'd3, 3'd5}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive_f(input logic [12:0] f);
        seq_tmo = f[12]; over_temp = f[11]; sys_lo = f[10]; sys_lo_off_en = f[9];
        sys_sd_lvl = f[8]; sw_off = f[7]; core_uv = f[6]; wdog_exp = f[5];
        wdog_dev_en = f[4]; ext_pin_low = f[3]; conv_uv = f[2]; conv_dev_en = f[1];
        sw_rst = f[0];
    endtask

    task automatic run_stretch(input logic [2:0] exp_src);
        int n = 0;
        int len = UNIT << rst_dur;
        startup_done = 1'b1;
        step();
        startup_done = 1'b0;
        while (pwr_state == 3'd4 && n < 2000) begin
            chk(rst_n == 1'b0, "R8 stretch rst_n", rst_n, 0);
            n++;
            step();
        end
        chk(n == len, "R9 stretch length", n, len);
        chk(pwr_state == 3'd5 && rst_n == 1'b1, "R8 on after stretch", pwr_state, 5);
        chk(on_src == exp_src, "R7 R10 on_src", on_src, exp_src);
    endtask

    task automatic bring_on();
        on_evt = 1'b1;
        step();
        on_evt = 1'b0;
        chk(pwr_state == 3'd3 && startup_req, "R2 startup", pwr_state, 3);
        chk(rst_n == 1'b0, "R8 startup rst_n", rst_n, 0);
        run_stretch(3'd1);
    endtask

    task automatic fault(input logic [12:0] f, input logic [2:0] est,
                         input logic [2:0] esrc, input string req);
        drive_f(f);
        step();
        drive_f('0);
        if (est == 3'd5) begin
            chk(pwr_state == 3'd5 && rst_n == 1'b1, {req, " ignored"}, pwr_state, 5);
            return;
        end
        chk(pwr_state == 3'd6 && shutdown_req, {req, " shutdown"}, pwr_state, 6);
        chk(rst_n == 1'b0, "R8 shutdown rst_n", rst_n, 0);
        shutdown_done = 1'b1;
        step();
        shutdown_done = 1'b0;
        chk(pwr_state == est, {req, " destination"}, pwr_state, est);
        if (est == 3'd3) begin
            chk(regmap_clr == 1'b1, "R6 regmap_clr", regmap_clr, 1);
            run_stretch(esrc);
            repeat (8) step();
        end else begin
            chk(rst_n == 1'b0, "R8 off rst_n", rst_n, 0);
            bring_on();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        chk(pwr_state == 3'd0, "R1 reset state", pwr_state, 0);
        chk(rst_n == 1'b0, "R1 reset rst_n", rst_n, 0);
        chk(on_src == 3'd0, "R1 reset on_src", on_src, 0);
        por_n = 1'b1;
        step();
        chk(pwr_state == 3'd1, "R1 off after por", pwr_state, 1);
        step();
        chk(pwr_state == 3'd1, "R14 off holds", pwr_state, 1);
        bring_on();
        repeat (8) step();

        for (int i = 0; i < 19; i++) begin
            logic [18:0] v = TBL[i];
            string rq;
            if (v[5:3] == 3'd1)      rq = "R3 R7";
            else if (v[5:3] == 3'd2) rq = "R4";
            else if (v[5:3] == 3'd3) rq = "R6 R7";
            else                     rq = "R5";
            fault(v[18:6], v[5:3], v[2:0], rq);
        end

        // R9: each stretch setting
        for (int d = 1; d < 4; d++) begin
            fault(13'h0080, 3'd1, 3'd0, "R3");
            rst_dur = 2'(d);
        end
        fault(13'h0080, 3'd1, 3'd0, "R3");
        rst_dur = 2'd0;
        fault(13'h0080, 3'd1, 3'd0, "R3");

        // R11: shared watchdog/converter cap
        stable_limit = 16'hFFFF;
        fault(13'h0080, 3'd1, 3'd0, "R2");
        for (int k = 0; k < 6; k++) fault(13'h0030, 3'd3, 3'd3, "R11");
        fault(13'h0006, 3'd1, 3'd0, "R11 cap");
        // R12: separate software cap, after filling the shared counter
        for (int k = 0; k < 6; k++) fault(13'h0030, 3'd3, 3'd3, "R11");
        for (int k = 0; k < 6; k++) fault(13'h0001, 3'd3, 3'd5, "R12");
        fault(13'h0001, 3'd1, 3'd0, "R12 cap");
        // R2: ON event cleared the counters
        fault(13'h0030, 3'd3, 3'd3, "R2 clear");
        fault(13'h0006, 3'd3, 3'd4, "R2 clear");

        // R14: cause ignored in OFF
        drive_f(13'h0080);
        step();
        drive_f('0);
        shutdown_done = 1'b1;
        step();
        shutdown_done = 1'b0;
        drive_f(13'h0008);
        step();
        drive_f('0);
        chk(pwr_state == 3'd1 && rst_n == 1'b0, "R14 off ignores", pwr_state, 1);
        bring_on();

        // R13: stable period clears counters
        stable_limit = 16'd4;
        for (int k = 0; k < 8; k++) fault(13'h0030, 3'd3, 3'd3, "R13");
        for (int k = 0; k < 8; k++) fault(13'h0001, 3'd3, 3'd5, "R13");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule